// File: doc/BRIEF.md
# Command Queue Consumer Engine

This block drains a circular queue of 16-byte commands that software places in memory for an I/O memory-management unit. Software programs a base address, the log2 of the queue's slot count and an enable. It then posts work by writing a producer index. Each producer write starts a consume run. The run fetches the entry at the consumer slot as four 32-bit words over a memory port that allows one read in flight. It decodes the opcode and then either retires the command or stops with an error. It repeats this until the consumer catches up with the producer.

Invalidate, prefetch and similar commands are accepted and retired with no further action. A sync command can request an interrupt pulse. An illegal opcode or a failed read halts the queue on the failing entry. In that case the block records an error code in the consumer register and toggles a global command-error flag. Nothing further is consumed until software acknowledges the error by matching its acknowledge bit to that flag.

Top module: `cmdq_consumer`

## Requirements
- R1: After reset the consumer register reads zero, the error flag is low, and no memory request or interrupt is active.
- R2: A producer-index write starts a run. The run consumes commands until the wrap-plus-index bits of the producer and consumer (the low log2size+1 bits) are equal. It then goes idle with the consumer equal to the producer.
- R3: The entry for a slot is read at (base with its low four bits cleared) + 16 × slot, where slot is the low log2size bits of the consumer. The four words are read at that address +0, +4, +8 and +12, in that order.
- R4: A retired command increments only the low log2size+1 bits of the consumer (bit log2size is the wrap flag), wrapping to zero after 2^(log2size+1) commands. The error field in bits [30:24] keeps its value.
- R5: Opcode = word 0 bits [7:0]. The accepted opcodes are 0x01–0x07, 0x10–0x13, 0x18, 0x1A, 0x20–0x23, 0x28, 0x2A, 0x30, 0x40, 0x41 and 0x44–0x46, and each one is retired. Any other value, including 0x00, writes code 1 into bits [30:24], leaves the index unchanged, pulses gerr_irq and toggles gerr_flag.
- R6: An error response on any word of a fetch writes code 2 into bits [30:24], leaves the index unchanged, pulses gerr_irq, toggles gerr_flag and issues no further reads for that command.
- R7: A retired sync command (0x46) pulses sync_irq for one cycle when word 0 bit 12 is set, and does not pulse it when bit 12 is clear. The pulse coincides with the consumer advance.
- R8: While gerr_flag differs from err_ack, no entry is fetched and the consumer is unchanged. A producer write made after the acknowledge resumes consumption at the entry that failed.
- R9: While q_enable is low, a producer write causes no fetch and the consumer is unchanged.
- R10: At most one read is outstanding: mem_req is never asserted while a response is awaited.
- R11: The consumer index changes only two cycles after the final word's good response, never at fetch time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_enable | input | 1 | Command processing enable |
| q_base | input | ADDR_W | Queue base address (low 4 bits ignored) |
| q_log2size | input | LOG2_W | log2 of slot count, clamped to MAX_LOG2 |
| prod_wr | input | 1 | Producer-index write strobe |
| prod_idx | input | IDX_W | Producer wrap-plus-index value |
| err_ack | input | 1 | Software's command-error acknowledge bit |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Read word address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response is an abort |
| cons_reg | output | 32 | Consumer register: index in low bits, error code in [30:24] |
| gerr_flag | output | 1 | Global command-error flag, toggled per error |
| sync_irq | output | 1 | Sync-completion interrupt pulse |
| gerr_irq | output | 1 | Global-error interrupt pulse |

## Verification
Two states are hard to reach from the ports. One is the halt on a pending error. The other is the abort in the middle of a fetch, which needs a failing response on an inner word. The bench's memory model fails one chosen word address, so an abort lands on the third word of an entry. It then counts the requests that follow. To show the halt, the bench reposts work after an error without acknowledging it, and checks that no request and no index change follows. It then acknowledges, reposts, and expects the same slot to run. A sweep over all 256 opcodes, with the acknowledge kept in step, covers every code as legal or illegal.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    localparam int ENTRY_SHIFT = 4;
    localparam int CMD_WORDS   = 4;
    localparam int WORD_W      = 32;
    localparam int ERR_LSB     = 24;
    localparam int ERR_W       = 7;
    localparam logic [7:0] OP_SYNC = 8'h46;

    typedef enum logic [1:0] {
        CERR_NONE    = 2'd0,
        CERR_ILLEGAL = 2'd1,
        CERR_ABORT   = 2'd2
    } cmd_err_e;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_CHECK,
        ENG_FETCH
    } eng_state_e;

    typedef struct packed {
        logic [17:0] rsvd_hi;
        logic [1:0]  notify;
        logic [3:0]  rsvd_lo;
        logic [7:0]  opcode;
    } cmd_head_t;

    typedef struct packed {
        logic legal;
        logic fire_sync;
    } cmd_dec_t;

    function automatic logic op_accepted(input logic [7:0] op);
        return op inside {[8'h01:8'h07], [8'h10:8'h13], 8'h18, 8'h1A,
                          [8'h20:8'h23], 8'h28, 8'h2A, 8'h30,
                          8'h40, 8'h41, [8'h44:8'h46]};
    endfunction

    function automatic cmd_dec_t decode_head(input cmd_head_t h);
        cmd_dec_t d;
        d.legal     = op_accepted(h.opcode);
        d.fire_sync = (h.opcode == OP_SYNC) && h.notify[0];
        return d;
    endfunction

endpackage

// File: rtl/cmdq_ptr.sv
module cmdq_ptr #(
    parameter int ADDR_W   = 32,
    parameter int MAX_LOG2 = 8,
    parameter int LOG2_W   = 4,
    parameter int IDX_W    = MAX_LOG2 + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LOG2_W-1:0]         log2size,
    input  logic [ADDR_W-1:0]         base,
    input  logic                      prod_wr,
    input  logic [IDX_W-1:0]          prod_in,
    input  logic                      cons_adv,
    input  logic                      err_wr,
    input  logic [cmdq_pkg::ERR_W-1:0] err_code,
    output logic [31:0]               cons_reg,
    output logic                      empty,
    output logic [ADDR_W-1:0]         entry_addr
);
    import cmdq_pkg::*;

    localparam int PAD_W = ERR_LSB - IDX_W;

    logic [LOG2_W-1:0] eff_log2;
    logic [IDX_W-1:0]  wrap_mask;
    logic [IDX_W-1:0]  slot_mask;
    logic [IDX_W-1:0]  prod_q;
    logic [IDX_W-1:0]  cons_idx;
    logic [ERR_W-1:0]  cons_err;

    always_comb begin
        eff_log2  = (log2size > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : log2size;
        wrap_mask = {IDX_W{1'b1}} >> (LOG2_W'(MAX_LOG2) - eff_log2);
        slot_mask = wrap_mask >> 1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q   <= '0;
            cons_idx <= '0;
            cons_err <= '0;
        end else begin
            if (prod_wr)  prod_q   <= prod_in;
            if (cons_adv) cons_idx <= (cons_idx + 1'b1) & wrap_mask;
            if (err_wr)   cons_err <= err_code;
        end
    end

    assign empty      = ((prod_q ^ cons_idx) & wrap_mask) == '0;
    assign entry_addr = (base & ~ADDR_W'((1 << ENTRY_SHIFT) - 1))
                      + (ADDR_W'(cons_idx & slot_mask) << ENTRY_SHIFT);
    assign cons_reg   = {1'b0, cons_err, {PAD_W{1'b0}}, cons_idx};

endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch #(
    parameter int ADDR_W = 32,
    parameter int WORDS  = cmdq_pkg::CMD_WORDS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  logic [ADDR_W-1:0]           entry_addr,
    output logic                        mem_req,
    output logic [ADDR_W-1:0]           mem_addr,
    input  logic                        mem_rvalid,
    input  logic [cmdq_pkg::WORD_W-1:0] mem_rdata,
    input  logic                        mem_rerr,
    output logic                        done,
    output logic                        abort,
    output cmdq_pkg::cmd_head_t         head
);
    import cmdq_pkg::*;

    localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

    logic              issuing;
    logic              waiting;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            issuing <= 1'b0;
            waiting <= 1'b0;
            cnt     <= '0;
            base_q  <= '0;
            done    <= 1'b0;
            abort   <= 1'b0;
            head    <= '0;
        end else begin
            done  <= 1'b0;
            abort <= 1'b0;
            if (start) begin
                issuing <= 1'b1;
                cnt     <= '0;
                base_q  <= entry_addr;
            end else if (issuing) begin
                issuing <= 1'b0;
                waiting <= 1'b1;
            end else if (waiting && mem_rvalid) begin
                waiting <= 1'b0;
                if (mem_rerr) begin
                    abort <= 1'b1;
                end else begin
                    if (cnt == '0) head <= cmd_head_t'(mem_rdata);
                    if (cnt == LAST) begin
                        done <= 1'b1;
                    end else begin
                        cnt     <= cnt + 1'b1;
                        issuing <= 1'b1;
                    end
                end
            end
        end
    end

    assign mem_req  = issuing;
    assign mem_addr = base_q + (ADDR_W'(cnt) << 2);

endmodule

// File: rtl/cmdq_consumer.sv
module cmdq_consumer #(
    parameter int ADDR_W   = 32,
    parameter int MAX_LOG2 = 8,
    parameter int LOG2_W   = $clog2(MAX_LOG2 + 1),
    parameter int IDX_W    = MAX_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_enable,
    input  logic [ADDR_W-1:0] q_base,
    input  logic [LOG2_W-1:0] q_log2size,
    input  logic              prod_wr,
    input  logic [IDX_W-1:0]  prod_idx,
    input  logic              err_ack,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic [31:0]       cons_reg,
    output logic              gerr_flag,
    output logic              sync_irq,
    output logic              gerr_irq
);
    import cmdq_pkg::*;

    eng_state_e        state;
    logic              empty;
    logic [ADDR_W-1:0] entry_addr;
    logic              pend;
    logic              start;
    logic              f_done;
    logic              f_abort;
    cmd_head_t         head;
    cmd_dec_t          dec;
    logic              cons_adv;
    logic              err_wr;
    logic [ERR_W-1:0]  err_code;
    logic              unused_head_bits;

    assign pend  = gerr_flag ^ err_ack;
    assign start = (state == ENG_CHECK) && q_enable && !empty && !pend;
    assign dec   = decode_head(head);
    assign unused_head_bits = ^{head.rsvd_hi, head.rsvd_lo, head.notify[1]};

    always_comb begin
        cons_adv = 1'b0;
        err_wr   = 1'b0;
        err_code = '0;
        if (state == ENG_FETCH) begin
            if (f_abort) begin
                err_wr   = 1'b1;
                err_code = ERR_W'(CERR_ABORT);
            end else if (f_done) begin
                if (dec.legal) begin
                    cons_adv = 1'b1;
                end else begin
                    err_wr   = 1'b1;
                    err_code = ERR_W'(CERR_ILLEGAL);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            gerr_flag <= 1'b0;
            sync_irq  <= 1'b0;
            gerr_irq  <= 1'b0;
        end else begin
            sync_irq <= 1'b0;
            gerr_irq <= 1'b0;
            unique case (state)
                ENG_IDLE:  if (prod_wr) state <= ENG_CHECK;
                ENG_CHECK: state <= start ? ENG_FETCH : ENG_IDLE;
                ENG_FETCH: begin
                    if (err_wr) begin
                        gerr_flag <= ~gerr_flag;
                        gerr_irq  <= 1'b1;
                        state     <= ENG_IDLE;
                    end else if (cons_adv) begin
                        sync_irq  <= dec.fire_sync;
                        state     <= ENG_CHECK;
                    end
                end
                default:   state <= ENG_IDLE;
            endcase
        end
    end

    cmdq_ptr #(
        .ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W), .IDX_W(IDX_W)
    ) u_ptr (
        .clk(clk), .rst(rst), .log2size(q_log2size), .base(q_base),
        .prod_wr(prod_wr), .prod_in(prod_idx), .cons_adv(cons_adv),
        .err_wr(err_wr), .err_code(err_code), .cons_reg(cons_reg),
        .empty(empty), .entry_addr(entry_addr)
    );

    cmdq_fetch #(
        .ADDR_W(ADDR_W), .WORDS(CMD_WORDS)
    ) u_fetch (
        .clk(clk), .rst(rst), .start(start), .entry_addr(entry_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_rerr(mem_rerr), .done(f_done),
        .abort(f_abort), .head(head)
    );

endmodule

// File: rtl/cmdq_consumer_chk.sv
module cmdq_consumer_chk #(
    parameter int IDX_W = 9
) (
    input logic        clk,
    input logic        rst,
    input logic        err_ack,
    input logic        mem_req,
    input logic        mem_rvalid,
    input logic        mem_rerr,
    input logic [31:0] cons_reg,
    input logic        gerr_flag,
    input logic        sync_irq,
    input logic        gerr_irq
);
    logic in_flight;
    logic pend;

    assign pend = gerr_flag ^ err_ack;

    always_ff @(posedge clk) begin
        if (rst)             in_flight <= 1'b0;
        else if (mem_req)    in_flight <= 1'b1;
        else if (mem_rvalid) in_flight <= 1'b0;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !in_flight); // R10

    AST_HALT_WHEN_PENDING: assert property (@(posedge clk) disable iff (rst)
        (pend && $past(pend)) |-> !mem_req); // R8

    AST_ADVANCE_AFTER_DATA: assert property (@(posedge clk) disable iff (rst)
        (cons_reg[IDX_W-1:0] != $past(cons_reg[IDX_W-1:0]))
            |-> ($past(mem_rvalid, 2) && !$past(mem_rerr, 2))); // R11

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sync_irq |=> !sync_irq); // R7

    AST_ERR_TOGGLES_FLAG: assert property (@(posedge clk) disable iff (rst)
        gerr_irq |-> (gerr_flag != $past(gerr_flag))); // R5

    AST_ERR_HOLDS_INDEX: assert property (@(posedge clk) disable iff (rst)
        gerr_irq |-> (cons_reg[IDX_W-1:0] == $past(cons_reg[IDX_W-1:0]))); // R6

    AST_ERR_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
        gerr_irq |-> (cons_reg[30:24] == 7'd1 || cons_reg[30:24] == 7'd2)); // R5

endmodule

bind cmdq_consumer cmdq_consumer_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .err_ack(err_ack), .mem_req(mem_req),
    .mem_rvalid(mem_rvalid), .mem_rerr(mem_rerr), .cons_reg(cons_reg),
    .gerr_flag(gerr_flag), .sync_irq(sync_irq), .gerr_irq(gerr_irq)
);

// File: tb/cmdq_consumer_bench.sv
module cmdq_consumer_bench;
    localparam int ADDR_W = 32;
    localparam int MAX_LOG2 = 8;
    localparam int LOG2_W = 4;
    localparam int IDX_W = 9;
    localparam logic [31:0] MEM_BASE = 32'h1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic q_enable = 1'b0;
    logic [ADDR_W-1:0] q_base = '0;
    logic [LOG2_W-1:0] q_log2size = '0;
    logic prod_wr = 1'b0;
    logic [IDX_W-1:0] prod_idx = '0;
    logic err_ack = 1'b0;
    logic mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic mem_rerr = 1'b0;
    logic [31:0] cons_reg;
    logic gerr_flag, sync_irq, gerr_irq;

    always #10 clk = ~clk;

    cmdq_consumer u_cmdq_consumer (
        .clk(clk), .rst(rst), .q_enable(q_enable), .q_base(q_base),
        .q_log2size(q_log2size), .prod_wr(prod_wr), .prod_idx(prod_idx),
        .err_ack(err_ack), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
        .cons_reg(cons_reg), .gerr_flag(gerr_flag), .sync_irq(sync_irq),
        .gerr_irq(gerr_irq)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // memory model: two-cycle latency, one word address may be made to fail
    logic [31:0] mem [0:1023];
    logic [31:0] fail_addr = 32'hFFFF_FFFF;
    logic [31:0] addr_log [$];

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rerr = 1'b0;
            if (!rst && mem_req) begin
                logic [31:0] a;
                a = mem_addr;
                addr_log.push_back(a);
                @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rerr = (a == fail_addr);
                mem_rdata = mem[10'((a - MEM_BASE) >> 2)];
            end
        end
    end

    // scoreboard
    typedef struct {
        bit          is_err;
        logic [31:0] cons;
        string       tag;
    } ev_t;
    ev_t exp_q [$];

    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (sync_irq || gerr_irq)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, sync_irq ? "R7 unexpected sync_irq" : "R5 unexpected gerr_irq",
                          {30'b0, sync_irq, gerr_irq}, 32'h0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check(e.is_err ? (gerr_irq && !sync_irq) : (sync_irq && !gerr_irq),
                          {e.tag, " irq kind"}, {30'b0, sync_irq, gerr_irq},
                          e.is_err ? 32'h1 : 32'h2);
                    check(cons_reg == e.cons, {e.tag, " cons at irq"}, cons_reg, e.cons);
                end
            end
        end
    end

    // expected model
    logic [IDX_W-1:0] exp_idx = '0;
    logic [6:0]       exp_err = '0;
    logic             exp_flag = 1'b0;

    function automatic bit ref_legal(input logic [7:0] op);
        case (op)
            8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
            8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
            8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30,
            8'h40, 8'h41, 8'h44, 8'h45, 8'h46: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_cons();
        return {1'b0, exp_err, 15'b0, exp_idx};
    endfunction

    function automatic logic [IDX_W-1:0] wmask();
        return IDX_W'((1 << (int'(q_log2size) + 1)) - 1);
    endfunction

    task automatic put_slot(input int slot, input logic [31:0] w0);
        mem[slot*4]     = w0;
        mem[slot*4 + 1] = ~w0;
        mem[slot*4 + 2] = w0 ^ 32'h5A5A_0000;
        mem[slot*4 + 3] = 32'hC0DE_0000 | slot;
    endtask

    task automatic post(input logic [IDX_W-1:0] v);
        @(negedge clk);
        prod_wr = 1'b1;
        prod_idx = v;
        @(negedge clk);
        prod_wr = 1'b0;
        repeat (110) @(negedge clk);
    endtask

    task automatic issue_cmd(input logic [31:0] w0, input string tag);
        int slot;
        logic [IDX_W-1:0] nxt;
        bit runs;
        slot = int'(exp_idx & (wmask() >> 1));
        nxt  = (exp_idx + 1'b1) & wmask();
        runs = q_enable && (exp_flag == err_ack);
        put_slot(slot, w0);
        addr_log.delete();
        if (runs) begin
            if (ref_legal(w0[7:0])) begin
                exp_idx = nxt;
                if (w0[7:0] == 8'h46 && w0[12]) exp_q.push_back('{1'b0, exp_cons(), tag});
            end else begin
                exp_err = 7'd1;
                exp_flag = ~exp_flag;
                exp_q.push_back('{1'b1, exp_cons(), tag});
            end
        end
        post(nxt);
        check(cons_reg == exp_cons(), {tag, " consumer register"}, cons_reg, exp_cons());
        check(gerr_flag == exp_flag, {tag, " error flag"}, {31'b0, gerr_flag}, {31'b0, exp_flag});
        check(exp_q.size() == 0, {tag, " missing irq"}, exp_q.size(), 0);
        if (runs)
            check(addr_log.size() > 0 && addr_log[0] == MEM_BASE + 32'(slot * 16),
                  {tag, " R3 first address"}, addr_log.size() > 0 ? addr_log[0] : 32'hDEAD,
                  MEM_BASE + 32'(slot * 16));
        else
            check(addr_log.size() == 0, {tag, " no fetch"}, addr_log.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1 reset state
        check(cons_reg == 32'h0, "R1 cons after reset", cons_reg, 32'h0);
        check(!gerr_flag && !mem_req && !sync_irq && !gerr_irq, "R1 outputs quiet",
              {28'b0, gerr_flag, mem_req, sync_irq, gerr_irq}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        q_enable = 1'b1;
        q_base = 32'h1007;     // low bits ignored
        q_log2size = 4'd2;     // four slots
        repeat (3) @(negedge clk);

        // R2/R3/R7: one run of three commands, sync with and without irq option
        put_slot(0, 32'h0000_0001);
        put_slot(1, 32'h0000_1046);
        put_slot(2, 32'h0000_2046);
        addr_log.delete();
        exp_q.push_back('{1'b0, 32'd2, "R7"});
        post(9'd3);
        exp_idx = 9'd3;
        check(cons_reg == 32'd3, "R2 run stops at producer", cons_reg, 32'd3);
        check(addr_log.size() == 12, "R3 request count", addr_log.size(), 12);
        for (int k = 0; k < 12; k++)
            if (k < addr_log.size())
                check(addr_log[k] == MEM_BASE + 32'(4 * k), "R3 word address order",
                      addr_log[k], MEM_BASE + 32'(4 * k));
        check(exp_q.size() == 0, "R7 sync irq seen", exp_q.size(), 0);

        // R4 wrap across the slot boundary
        put_slot(3, 32'h0000_0020);
        put_slot(0, 32'h0000_002A);
        put_slot(1, 32'h0000_1046);
        exp_q.push_back('{1'b0, 32'd6, "R4"});
        post(9'd6);
        exp_idx = 9'd6;
        check(cons_reg == 32'd6, "R4 wrap flag set after wrap", cons_reg, 32'd6);

        // R5 illegal opcode 0x00
        issue_cmd(32'h0000_0000, "R5");
        // R8 pending error blocks progress
        issue_cmd(32'h0000_0030, "R8");
        err_ack = 1'b1;
        // R8 resumes at failed slot; R4 error field preserved
        issue_cmd(32'h0000_0030, "R4");
        // R9 disabled
        q_enable = 1'b0;
        issue_cmd(32'h0000_0041, "R9");
        q_enable = 1'b1;
        issue_cmd(32'h0000_0041, "R9");

        // R6 abort on third word
        put_slot(0, 32'h0000_0001);
        fail_addr = MEM_BASE + 32'h8;
        addr_log.delete();
        exp_err = 7'd2;
        exp_flag = ~exp_flag;
        exp_q.push_back('{1'b1, exp_cons(), "R6"});
        post(9'd1);
        check(addr_log.size() == 3, "R6 no reads after abort", addr_log.size(), 3);
        check(cons_reg == exp_cons(), "R6 code 2 and index held", cons_reg, exp_cons());
        check(gerr_flag == exp_flag, "R6 flag toggled", {31'b0, gerr_flag}, {31'b0, exp_flag});
        fail_addr = 32'hFFFF_FFFF;

        // R5 full opcode sweep
        for (int op = 0; op < 256; op++) begin
            err_ack = exp_flag;
            issue_cmd({24'b0, 8'(op)}, "R5");
        end

        // R7 sync with notify field 3
        err_ack = exp_flag;
        issue_cmd(32'h0000_3046, "R7");

        // R4 single-slot queue
        q_log2size = 4'd0;
        issue_cmd(32'h0000_0010, "R4");
        issue_cmd(32'h0000_0011, "R4");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule